// File: doc/BRIEF.md
# Serial Controller External-Status Interrupt Unit

This block models the host-facing register and interrupt path of a serial communication controller. A microprocessor reaches it over an 8-bit bus with active-low read and write strobes. A pointer, loaded through control register 0, steers each access to one of sixteen register slots. The block watches three modem-status pins (clear-to-send, sync and carrier detect) and shows them in status register 0. When the host has enabled it, a change on clear-to-send latches the status bits and raises an interrupt request. The block takes part in an interrupt daisy chain. On an acknowledge it drives the stored 8-bit vector onto the bus.

The interrupt path is one state machine with four named states. ST_IDLE means no interrupt is pending or in service, and the status bits follow the pins. ST_PEND means an interrupt is pending and the request may be driven. ST_SERV means the interrupt is pending and under service. ST_SVCLR means the interrupt is under service with the pending state cleared. The transitions are named as follows. Raise runs ST_IDLE to ST_PEND on an enabled clear-to-send edge. Ack runs ST_PEND to ST_SERV on an acknowledge. Drop runs ST_PEND to ST_IDLE on the reset-status command. Clear runs ST_SERV to ST_SVCLR on the reset-status command. Re-pend runs ST_SERV to ST_PEND on the end-of-service command. Release runs ST_SVCLR to ST_IDLE on the end-of-service command. The host cannot write the pending state. It can only provoke it through a pin edge.

Top module: `esc_irq_unit`

## Requirements
- R1: Holding `rd_n` and `wr_n` low together resets the block. All stored registers return to 0x00, the pointer returns to 0 and the state machine returns to ST_IDLE. No access is performed while the strobes are released.
- R2: After any reset, status register 0 (pointer 0) reads with bit 6 and bit 2 set and bits 7, 1 and 0 clear.
- R3: In ST_IDLE, status register 0 bit 5 equals `cts`, bit 4 equals `sync_in` and bit 3 equals `dcd`.
- R4: A write at pointer 0 loads the pointer from data bits 2:0. If data bits 5:3 equal 3'b001, 8 is added to the pointer. After the next completed read or write at a nonzero pointer, the pointer returns to 0.
- R5: Registers 2, 12, 13 and 15 read back the last value written to them. Register 2 holds the interrupt vector.
- R6: A clear-to-send change raises the pending state (Raise) only if register 15 bit 5 and register 1 bit 0 are both set. The pending state reads as bit 3 of status register 3.
- R7: `int_n` is low exactly when the state is ST_PEND, register 9 bit 3 is set and `iei` is high.
- R8: A falling edge on `intack_n` in ST_PEND, with `iei` high and register 9 bit 3 set, takes Ack. `data_out` then carries register 2 unmodified with `data_oe` high until `intack_n` rises.
- R9: In ST_SERV and ST_SVCLR, `int_n` stays high and status register 0 bits 5:3 keep the values captured at Raise, whatever the pins do.
- R10: Writing 0x10 at pointer 0 clears the pending state (Drop or Clear). Writing 0x38 at pointer 0 clears the in-service state. Once both have been written the block is in ST_IDLE, the status bits follow the pins, and a new clear-to-send change raises an interrupt again.
- R11: Writing any value to register 3 leaves status register 3 unchanged, so the pending bit cannot be set by the host.
- R12: Writing 0x38 in ST_SERV returns the block to ST_PEND (Re-pend), and `int_n` is driven low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data or interrupt vector |
| data_oe | output | 1 | High while the block drives `data_out` |
| cts | input | 1 | Clear-to-send modem pin |
| sync_in | input | 1 | Sync modem pin |
| dcd | input | 1 | Carrier-detect modem pin |
| intack_n | input | 1 | Active-low interrupt acknowledge |
| iei | input | 1 | Daisy-chain enable in |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The interrupt state is visible at the ports within the cycle after each strobe edge. A state machine that skips ST_SVCLR or ST_PEND shows up as the wrong `int_n` level, or as a wrong pending bit in status register 3, after the next command write. A status latch that opens too early shows live pin values in status register 0 while under service. A pointer that fails to return to 0 turns the next plain status read into a register read.

// File: rtl/esc_pkg.sv
package esc_pkg;
    localparam int PTR_W = 4;
    localparam int NREG  = 1 << PTR_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_SERV  = 2'd2,
        ST_SVCLR = 2'd3
    } irq_state_t;

    localparam logic [2:0] CMD_POINT_HI = 3'b001;
    localparam logic [2:0] CMD_RST_ES   = 3'b010;
    localparam logic [2:0] CMD_RST_IUS  = 3'b111;

    localparam logic [PTR_W-1:0] IDX_STAT0 = 4'd0;
    localparam logic [PTR_W-1:0] IDX_STAT3 = 4'd3;
    localparam logic [PTR_W-1:0] IDX_VECT  = 4'd2;
    localparam logic [PTR_W-1:0] IDX_SRCEN = 4'd15;

    // slots that hold host data: 1, 2, 9, 12, 13, 15
    localparam logic [NREG-1:0] KEEP_MASK = 16'b1011_0010_0000_0110;
endpackage

// File: rtl/esc_bus_if.sv
module esc_bus_if
    import esc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [DW-1:0]    data_in,
    output logic             hw_rst,
    output logic             rd_act,
    output logic             wr_stb,
    output logic [DW-1:0]    wdat,
    output logic [PTR_W-1:0] ptr,
    output logic             cmd_rst_es,
    output logic             cmd_rst_ius
);
    logic rd_q, wr_q, blk_q, rd_end;
    logic [PTR_W-1:0] ptr_q;
    logic [DW-1:0]    wdat_q;

    assign hw_rst = !rd_n && !wr_n;
    assign wr_stb = wr_n && !wr_q && !blk_q;
    assign rd_end = rd_n && !rd_q && !blk_q;
    assign rd_act = !rd_n && wr_n && !blk_q;
    assign wdat   = wdat_q;
    assign ptr    = ptr_q;

    assign cmd_rst_es  = wr_stb && (ptr_q == '0) && (wdat_q[5:3] == CMD_RST_ES);
    assign cmd_rst_ius = wr_stb && (ptr_q == '0) && (wdat_q[5:3] == CMD_RST_IUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= 1'b1;
            wr_q   <= 1'b1;
            blk_q  <= 1'b0;
            wdat_q <= '0;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
            if (hw_rst)
                blk_q <= 1'b1;
            else if (rd_n && wr_n)
                blk_q <= 1'b0;
            if (!wr_n)
                wdat_q <= data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (hw_rst)
            ptr_q <= '0;
        else if (wr_stb && ptr_q == '0)
            ptr_q <= PTR_W'({(wdat_q[5:3] == CMD_POINT_HI), wdat_q[2:0]});
        else if ((wr_stb || rd_end) && ptr_q != '0)
            ptr_q <= '0;
    end

    // R1: strobe reset clears the pointer
    p_hwrst_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst |=> (ptr_q == '0));

    // R4: pointer returns to zero after a nonzero access
    p_ptr_return_r4: assert property (@(posedge clk) disable iff (!rst_n || hw_rst)
        ((wr_stb || rd_end) && ptr_q != '0) |=> (ptr_q == '0));
endmodule

// File: rtl/esc_regfile.sv
module esc_regfile
    import esc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_rst,
    input  logic             wr_stb,
    input  logic [PTR_W-1:0] ptr,
    input  logic [DW-1:0]    wdat,
    input  logic [DW-1:0]    stat0,
    input  logic             ip,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    vector,
    output logic             es_ie,
    output logic             cts_ie,
    output logic             mie
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (KEEP_MASK[g]) begin : g_keep
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (hw_rst)
                    q <= '0;
                else if (wr_stb && ptr == PTR_W'(g))
                    q <= wdat;
            end
            assign regs[g] = q;
        end else begin : g_none
            assign regs[g] = '0;
        end
    end

    assign vector = regs[IDX_VECT];
    assign es_ie  = regs[1][0];
    assign mie    = regs[9][3];
    assign cts_ie = regs[IDX_SRCEN][5];

    always_comb begin
        unique case (ptr)
            IDX_STAT0: rd_data = stat0;
            IDX_STAT3: rd_data = DW'({ip, 3'b000});
            default:   rd_data = regs[ptr];
        endcase
    end

    // R5: source-enable register changes only on its own write
    p_keep_srcen_r5: assert property (@(posedge clk) disable iff (!rst_n || hw_rst)
        !(wr_stb && ptr == IDX_SRCEN) |=> $stable(regs[IDX_SRCEN]));

    // R1: strobe reset clears the vector register
    p_hwrst_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst |=> (regs[IDX_VECT] == '0));
endmodule

// File: rtl/esc_irq_fsm.sv
module esc_irq_fsm
    import esc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst,
    input  logic       cts,
    input  logic       sync_in,
    input  logic       dcd,
    input  logic       cts_ie,
    input  logic       es_ie,
    input  logic       mie,
    input  logic       iei,
    input  logic       intack_n,
    input  logic       rst_es,
    input  logic       rst_ius,
    output logic [2:0] status,
    output logic       ip,
    output logic       int_n,
    output logic       vec_oe
);
    irq_state_t state_q, state_d;
    logic       cts_q, ack_q, vec_q, cts_chg, ack_fall, take_ack, open_w;
    logic [2:0] live, stat_q;

    assign live     = {cts, sync_in, dcd};
    assign cts_chg  = cts != cts_q;
    assign ack_fall = !intack_n && ack_q;
    assign take_ack = ack_fall && iei && mie;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cts_chg && cts_ie && es_ie) state_d = ST_PEND;
            ST_PEND:  if (rst_es)        state_d = ST_IDLE;
                      else if (take_ack) state_d = ST_SERV;
            ST_SERV:  if (rst_es)        state_d = ST_SVCLR;
                      else if (rst_ius)  state_d = ST_PEND;
            ST_SVCLR: if (rst_ius)       state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (hw_rst) state_q <= ST_IDLE;
        else             state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_q  <= 1'b0;
            ack_q  <= 1'b1;
            vec_q  <= 1'b0;
            stat_q <= '0;
        end else begin
            cts_q <= cts;
            ack_q <= intack_n;
            if (hw_rst)
                vec_q <= 1'b0;
            else if (take_ack && state_q == ST_PEND)
                vec_q <= 1'b1;
            else if (intack_n)
                vec_q <= 1'b0;
            if (hw_rst || state_q == ST_IDLE)
                stat_q <= live;
        end
    end

    // outputs
    always_comb begin
        open_w = 1'b0;
        ip     = 1'b0;
        int_n  = 1'b1;
        unique case (state_q)
            ST_IDLE:  open_w = 1'b1;
            ST_PEND:  begin ip = 1'b1; int_n = !(mie && iei); end
            ST_SERV:  ip = 1'b1;
            ST_SVCLR: ip = 1'b0;
            default:  open_w = 1'b1;
        endcase
        status = open_w ? live : stat_q;
        vec_oe = vec_q;
    end

    // R6: raise only with both enables and a pin edge
    p_raise_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n || hw_rst)
        (state_q == ST_PEND && $past(state_q) == ST_IDLE) |-> $past(cts_ie && es_ie && cts_chg));

    // R9: no request while under service
    p_quiet_service_r9: assert property (@(posedge clk) disable iff (!rst_n || hw_rst)
        (state_q == ST_SERV || state_q == ST_SVCLR) |-> int_n);

    // R9: captured status holds while the latch is closed
    p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || hw_rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(stat_q));

    // R8: vector is driven only after an acknowledge taken while pending
    p_vec_from_pend_r8: assert property (@(posedge clk) disable iff (!rst_n || hw_rst)
        $rose(vec_q) |-> ($past(state_q) == ST_PEND && state_q == ST_SERV));
endmodule

// File: rtl/esc_irq_unit.sv
module esc_irq_unit
    import esc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic          cts,
    input  logic          sync_in,
    input  logic          dcd,
    input  logic          intack_n,
    input  logic          iei,
    output logic          int_n
);
    logic             hw_rst, rd_act, wr_stb, rst_es, rst_ius;
    logic             es_ie, cts_ie, mie, ip, vec_oe;
    logic [DW-1:0]    wdat, rd_data, vector, stat0;
    logic [PTR_W-1:0] ptr;
    logic [2:0]       status;

    // status register 0: bit6/bit2 fixed high, bits 7,1,0 low, 5:3 modem status
    assign stat0 = DW'({1'b0, 1'b1, status, 1'b1, 1'b0, 1'b0});

    esc_bus_if #(.DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in),
        .hw_rst(hw_rst), .rd_act(rd_act), .wr_stb(wr_stb), .wdat(wdat), .ptr(ptr),
        .cmd_rst_es(rst_es), .cmd_rst_ius(rst_ius)
    );

    esc_regfile #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .wr_stb(wr_stb), .ptr(ptr),
        .wdat(wdat), .stat0(stat0), .ip(ip), .rd_data(rd_data), .vector(vector),
        .es_ie(es_ie), .cts_ie(cts_ie), .mie(mie)
    );

    esc_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .cts(cts), .sync_in(sync_in),
        .dcd(dcd), .cts_ie(cts_ie), .es_ie(es_ie), .mie(mie), .iei(iei),
        .intack_n(intack_n), .rst_es(rst_es), .rst_ius(rst_ius), .status(status),
        .ip(ip), .int_n(int_n), .vec_oe(vec_oe)
    );

    assign data_out = vec_oe ? vector : rd_data;
    assign data_oe  = vec_oe || rd_act;
endmodule

// File: tb/esc_irq_unit_tb.sv
`timescale 1ns/1ps
module esc_irq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic       cts = 1'b0, sync_in = 1'b0, dcd = 1'b0;
    logic       intack_n = 1'b1, iei = 1'b1;
    logic       int_n;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    esc_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .cts(cts), .sync_in(sync_in),
        .dcd(dcd), .intack_n(intack_n), .iei(iei), .int_n(int_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] d);
        @(negedge clk); data_in = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic point(input int p);
        if (p != 0) bus_wr(8'((p & 7) | ((p >= 8) ? 8'h08 : 8'h00)));
    endtask

    task automatic wr_reg(input int p, input logic [7:0] v);
        point(p);
        bus_wr(v);
    endtask

    task automatic rd_reg(input int p, output logic [7:0] v);
        point(p);
        @(negedge clk); rd_n = 1'b0;
        #1 v = data_out;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic toggle_cts();
        @(negedge clk); cts = ~cts;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 int_n after reset", {7'd0, int_n}, 8'h01);
        chk("R1 data_oe idle", {7'd0, data_oe}, 8'h00);
        rd_reg(0, v);
        chk("R2 status reg 0 reset", v, 8'h44);
    endtask

    task automatic t_pins();
        logic [7:0] v;
        cts = 1'b1; dcd = 1'b1;
        rd_reg(0, v);
        chk("R3 cts+dcd", v, 8'h6C);
        cts = 1'b0; dcd = 1'b0; sync_in = 1'b1;
        rd_reg(0, v);
        chk("R3 sync only", v, 8'h54);
        sync_in = 1'b0;
    endtask

    task automatic t_rw();
        logic [7:0] v;
        wr_reg(12, 8'hA5);
        wr_reg(13, 8'h3C);
        wr_reg(2, 8'h5B);
        wr_reg(15, 8'h00);
        rd_reg(12, v); chk("R5 reg 12", v, 8'hA5);
        rd_reg(13, v); chk("R5 reg 13", v, 8'h3C);
        rd_reg(2, v);  chk("R5 reg 2", v, 8'h5B);
        wr_reg(15, 8'h20);
        rd_reg(15, v); chk("R5 reg 15", v, 8'h20);
        rd_reg(0, v);  chk("R4 pointer back to 0 after read", v, 8'h44);
        wr_reg(13, 8'h77);
        rd_reg(0, v);  chk("R4 pointer back to 0 after write", v, 8'h44);
        rd_reg(13, v); chk("R4 point-high reaches 13", v, 8'h77);
    endtask

    task automatic t_ip_nowrite();
        logic [7:0] v;
        wr_reg(3, 8'hFF);
        rd_reg(3, v);
        chk("R11 pending not writable", v, 8'h00);
    endtask

    task automatic t_hwrst();
        logic [7:0] v;
        point(12);
        @(negedge clk); rd_n = 1'b0; wr_n = 1'b0; data_in = 8'hEE;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        rd_reg(0, v);  chk("R1 pointer cleared", v, 8'h44);
        rd_reg(12, v); chk("R1 reg 12 cleared", v, 8'h00);
        rd_reg(15, v); chk("R1 reg 15 cleared", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr_reg(15, 8'h20);
        wr_reg(1, 8'h01);
        wr_reg(2, 8'h5B);
        iei = 1'b1;
        toggle_cts();
        rd_reg(3, v);
        chk("R6 pending set", v, 8'h08);
        chk("R7 no request without master enable", {7'd0, int_n}, 8'h01);
        wr_reg(9, 8'h08);
        chk("R7 request asserted", {7'd0, int_n}, 8'h00);
        @(negedge clk); iei = 1'b0;
        #1 chk("R7 chain blocks request", {7'd0, int_n}, 8'h01);
        @(negedge clk); iei = 1'b1;
        #1 chk("R7 chain releases request", {7'd0, int_n}, 8'h00);
        @(negedge clk); intack_n = 1'b0;
        @(negedge clk);
        chk("R8 vector on bus", data_out, 8'h5B);
        chk("R8 vector drive enable", {7'd0, data_oe}, 8'h01);
        chk("R9 request off in service", {7'd0, int_n}, 8'h01);
        intack_n = 1'b1;
        @(negedge clk);
        chk("R8 drive released", {7'd0, data_oe}, 8'h00);
        cts = 1'b0;
        rd_reg(0, v);
        chk("R9 status held in service", v, 8'h64);
        bus_wr(8'h10);
        rd_reg(3, v);
        chk("R10 pending cleared", v, 8'h00);
        chk("R10 no request in clear state", {7'd0, int_n}, 8'h01);
        rd_reg(0, v);
        chk("R9 status held after clear", v, 8'h64);
        bus_wr(8'h38);
        rd_reg(0, v);
        chk("R10 latch reopened", v, 8'h44);
        chk("R10 idle request off", {7'd0, int_n}, 8'h01);
        toggle_cts();
        chk("R10 re-armed request", {7'd0, int_n}, 8'h00);
    endtask

    task automatic t_repend();
        logic [7:0] v;
        @(negedge clk); intack_n = 1'b0;
        @(negedge clk); intack_n = 1'b1;
        @(negedge clk);
        chk("R12 in service", {7'd0, int_n}, 8'h01);
        bus_wr(8'h38);
        chk("R12 request again", {7'd0, int_n}, 8'h00);
        bus_wr(8'h10);
        chk("R10 drop to idle", {7'd0, int_n}, 8'h01);
        rd_reg(3, v);
        chk("R10 pending clear in idle", v, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr_reg(1, 8'h00);
        toggle_cts();
        rd_reg(3, v);
        chk("R6 no pending when source disabled", v, 8'h00);
        chk("R6 no request when source disabled", {7'd0, int_n}, 8'h01);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pins();
        t_rw();
        t_ip_nowrite();
        t_hwrst();
        t_irq();
        t_repend();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule